// File: doc/BRIEF.md
# Pipelined no-turnaround synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM. It accepts a read or a write on every enabled clock edge, in any mix, with no idle cycle needed between them. The address, the read/write select, the byte write enables and the chip selects are all registered on the rising clock edge. Write data follows its address by two enabled edges, and read data leaves the block after the same delay. Because both directions share that delay, a read can follow a write on the very next cycle and the data bus never needs a turnaround slot.

A load/advance input either loads a new external address or steps an internal two-bit burst counter. A burst keeps the direction and the selection state of the load that started it. An active-low clock enable freezes every register in the block. An asynchronous active-low output enable gates only the output drivers. The shared data bus is modelled as separate input, output and drive-enable ports.

Top module: `nt_sram`

## Requirements
- R1: After reset and until the first access reaches the data stage, data_oe_o is low.
- R2: A read loaded on an enabled edge drives data_o with the addressed word after the second enabled edge that follows the load. data_oe_o is high, provided oe_ni is low, until the next enabled edge.
- R3: A write loaded on an enabled edge stores data_i as sampled on the second enabled edge after the load. Reads and writes may be issued on consecutive edges in any order.
- R4: Byte enable bwe_ni[k] is sampled with its address. When it is low, bits [9k+8:9k] of the word are written; when it is high, those bits keep their old value.
- R5: A load cycle with ce0_ni high, ce1_ni high or ce2_i low is a deselect. It writes nothing, and data_oe_o stays low in its data slot.
- R6: On an advance cycle (ld_ni high), we_ni and the three chip enables are ignored. The burst keeps the direction and selection of its load.
- R7: On each advance the low two address bits increment modulo 4 and the upper bits stay fixed.
- R8: An advance that follows a deselect stays deselected, as does an advance that follows reset before any load.
- R9: While cen_ni is high, no register changes. No write takes place, and data_o holds its value.
- R10: oe_ni high forces data_oe_o low at once, without waiting for a clock edge.
- R11: A read issued on the edge right after a write to the same address returns the newly written word, merged lane by lane with the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; high freezes the block |
| ld_ni | input | 1 | Low loads a new address, high advances the burst |
| we_ni | input | 1 | Read/write select on load cycles, low = write |
| bwe_ni | input | LANES | Per-lane write enables, active low |
| ce0_ni | input | 1 | Chip enable, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| data_i | input | LANES*LANE_W | Write data bus |
| data_o | output | LANES*LANE_W | Read data bus |
| data_oe_o | output | 1 | Output driver enable for data_o |

## Verification
The bench builds the block with ADDR_W = 4, so the array holds only 16 words. With so few words, random addresses often land on a word written a few cycles earlier, which exercises the read-after-write merge. Every load address also sits near a burst wrap point. The default four 9-bit lanes are kept, so each bwe_ni pattern is checked against its own slice of the word. Random clock-enable stalls and chip-select drops fall inside bursts and between back-to-back accesses that alternate direction.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  localparam int unsigned BURST_W = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/nt_sram_burst.sv
// Address/control capture stage; holds the burst state between loads.
module nt_sram_burst
  import nt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_ni,
  input  logic              we_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bwe_ni,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bwe_no
);
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]  bwe_q;

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    if (!ld_ni) begin
      addr_d = addr_i;
      if (!sel_i)     op_d = OP_NONE;
      else if (we_ni) op_d = OP_RD;
      else            op_d = OP_WR;
    end else begin
      // linear wrap inside a four-word group
      addr_d[BURST_W-1:0] = addr_q[BURST_W-1:0] + BURST_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      bwe_q  <= '1;
    end else if (en_i) begin
      op_q   <= op_d;
      addr_q <= addr_d;
      bwe_q  <= bwe_ni;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign bwe_no = bwe_q;
endmodule

// File: rtl/nt_sram_stage.sv
module nt_sram_stage
  import nt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bwe_ni,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bwe_no
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  bwe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      bwe_q  <= '1;
    end else if (en_i) begin
      op_q   <= op_i;
      addr_q <= addr_i;
      bwe_q  <= bwe_ni;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign bwe_no = bwe_q;
endmodule

// File: rtl/nt_sram_array.sv
// Commit stage: writes and reads both resolve here, so older writes have
// always landed before a younger read samples the array.
module nt_sram_array
  import nt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  op_e                     op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        bwe_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic rvalid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (en_i && op_i == OP_WR && !bwe_ni[g])
        mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    rd_q <= '0;
      else if (en_i && op_i == OP_RD) rd_q <= mem_q[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rvalid_q <= 1'b0;
    else if (en_i) rvalid_q <= (op_i == OP_RD);
  end

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ld_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bwe_ni,
  input  logic              ce0_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              en;
  logic              sel;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_bwe_n, s2_bwe_n;
  logic              rd_valid;

  assign en  = !cen_ni;
  assign sel = !ce0_ni && !ce1_ni && ce2_i;

  nt_sram_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .ld_ni  (ld_ni),
    .we_ni  (we_ni),
    .sel_i  (sel),
    .addr_i (addr_i),
    .bwe_ni (bwe_ni),
    .op_o   (s1_op),
    .addr_o (s1_addr),
    .bwe_no (s1_bwe_n)
  );

  nt_sram_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .op_i   (s1_op),
    .addr_i (s1_addr),
    .bwe_ni (s1_bwe_n),
    .op_o   (s2_op),
    .addr_o (s2_addr),
    .bwe_no (s2_bwe_n)
  );

  nt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .op_i     (s2_op),
    .addr_i   (s2_addr),
    .bwe_ni   (s2_bwe_n),
    .wdata_i  (data_i),
    .rdata_o  (data_o),
    .rvalid_o (rd_valid)
  );

  // output enable is asynchronous: no register after this gate
  assign data_oe_o = rd_valid && !oe_ni;
endmodule

// File: rtl/nt_sram_chk.sv
module nt_sram_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              ld_ni,
  input logic              we_ni,
  input logic              ce0_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              oe_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [1:0]        s1_op,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              rd_valid
);
  logic chip_on;
  assign chip_on = !ce0_ni && !ce1_ni && ce2_i;

  p_read_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && chip_on && we_ni) ##1 !cen_ni ##1 !cen_ni |=> rd_valid);

  p_write_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && chip_on && !we_ni) ##1 !cen_ni ##1 !cen_ni |=> !rd_valid);

  p_deselect_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !ld_ni && !chip_on) ##1 !cen_ni ##1 !cen_ni |=> !rd_valid);

  p_adv_keeps_op_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && ld_ni) |=> $stable(s1_op));

  p_burst_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && ld_ni) |=> (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1)
                       && (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable(data_o) && $stable(rd_valid) && $stable(s1_addr) && $stable(s1_op));

  p_oe_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);
endmodule

bind nt_sram nt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cen_ni    (cen_ni),
  .ld_ni     (ld_ni),
  .we_ni     (we_ni),
  .ce0_ni    (ce0_ni),
  .ce1_ni    (ce1_ni),
  .ce2_i     (ce2_i),
  .oe_ni     (oe_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .s1_op     (s1_op),
  .s1_addr   (s1_addr),
  .rd_valid  (rd_valid)
);

// File: tb/nt_sram_test.sv
module nt_sram_test;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cen_n = 1'b1, ld_n = 1'b0, we_n = 1'b1;
  logic [3:0]    bwe_n = 4'hf;
  logic          ce0_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          oe_n = 1'b0;
  logic [35:0]   din = '0;
  logic [35:0]   dout;
  logic          doe;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";

  nt_sram #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_n), .ld_ni(ld_n), .we_ni(we_n),
    .bwe_ni(bwe_n), .ce0_ni(ce0_n), .ce1_ni(ce1_n), .ce2_i(ce2), .addr_i(addr),
    .oe_ni(oe_n), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  always #5 clk = ~clk;

  // behavioural reference: queue of issued accesses, retired two enabled edges later
  typedef struct {
    bit         v;
    bit         w;
    int         a;
    logic [3:0] bw;
  } acc_t;

  acc_t        pend[$];
  bit          m_v = 0, m_w = 0;
  int          m_a = 0;
  logic [35:0] ref_mem [DEPTH];
  bit          exp_drv = 0;
  logic [35:0] exp_dat = '0;

  always @(posedge clk) begin
    acc_t o;
    if (!rst_n) begin
      pend.delete();
      m_v = 0; m_a = 0; exp_drv = 0;
    end else if (!cen_n) begin
      exp_drv = 0;
      if (pend.size() == 2) begin
        o = pend.pop_front();
        if (o.v && o.w)
          for (int k = 0; k < 4; k++)
            if (!o.bw[k]) ref_mem[o.a][k*9 +: 9] = din[k*9 +: 9];
        if (o.v && !o.w) begin
          exp_drv = 1;
          exp_dat = ref_mem[o.a];
        end
      end
      if (!ld_n) begin
        m_v = !ce0_n && !ce1_n && ce2;
        m_w = !we_n;
        m_a = int'(addr);
      end else begin
        m_a = (m_a & ~3) | ((m_a + 1) & 3);
      end
      pend.push_back('{m_v, m_w, m_a, bwe_n});
    end
  end

  task automatic check(input bit ok, input string what, input logic [35:0] got, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      check(doe === (exp_drv && !oe_n), "drive", 36'(doe), 36'(exp_drv && !oe_n));
      if (exp_drv) check(dout === exp_dat, "data", dout, exp_dat);
    end
  end

  task automatic tick(input bit cen, input bit ld, input bit we, input bit c0, input bit c1,
                      input bit c2, input int a, input logic [3:0] bw);
    cen_n = cen; ld_n = ld; we_n = we; ce0_n = c0; ce1_n = c1; ce2 = c2;
    addr = AW'(a); bwe_n = bw;
    din = {4'($urandom()), 32'($urandom())};
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [3:0] bw); tick(0, 0, 0, 0, 0, 1, a, bw); endtask
  task automatic rd(input int a);                       tick(0, 0, 1, 0, 0, 1, a, 4'hf); endtask
  task automatic dsel();                                tick(0, 0, 0, 1, 0, 1, 0, 4'h0); endtask
  task automatic adv(input bit we, input logic [3:0] bw); tick(0, 1, we, 1, 1, 0, int'($urandom()), bw); endtask
  task automatic stall();
    tick(1, 1'($urandom()), 1'($urandom()), 0, 0, 1, int'($urandom()), 4'($urandom()));
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check(doe === 1'b0, "reset drive", 36'(doe), 36'd0);
    cur_req = "R8";  // advance straight out of reset: no write may land
    adv(0, 4'h0); adv(0, 4'h0);
    cur_req = "R3";
    for (int a = 0; a < DEPTH; a++) wr(a, 4'h0);
    dsel(); dsel();
    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++) rd(a);
    cur_req = "R11";
    for (int i = 0; i < 8; i++) begin
      wr(i, 4'h0); rd(i); wr(i, 4'b0101); rd(i); rd(i + 1); wr(i + 1, 4'b1010);
    end
    cur_req = "R4";
    for (int p = 0; p < 16; p++) begin wr(p, 4'(p)); rd(p); end
    cur_req = "R5";
    tick(0, 0, 0, 1, 0, 1, 3, 4'h0); rd(3);
    tick(0, 0, 0, 0, 1, 1, 4, 4'h0); rd(4);
    tick(0, 0, 0, 0, 0, 0, 5, 4'h0); rd(5);
    tick(0, 0, 1, 0, 1, 0, 6, 4'hf); rd(6);
    cur_req = "R8";
    dsel(); adv(0, 4'h0); adv(0, 4'h0); adv(0, 4'h0);
    for (int a = 0; a < 4; a++) rd(a);
    cur_req = "R7";
    wr(6, 4'h0); adv(1, 4'h0); adv(1, 4'h0); adv(1, 4'h0); adv(1, 4'h0);
    cur_req = "R6";
    rd(6); adv(0, 4'h0); adv(0, 4'h0); adv(0, 4'h0); adv(0, 4'h0); rd(14);
    cur_req = "R9";
    wr(9, 4'h0); stall(); stall(); rd(9); stall(); stall(); stall(); wr(9, 4'b0011);
    stall(); rd(9); stall(); dsel(); stall(); dsel(); stall();
    cur_req = "R10";
    for (int i = 0; i < 12; i++) begin
      oe_n = 1'($urandom());
      rd(i);
    end
    oe_n = 1'b0;
    cur_req = "R11";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom() % 16);
      oe_n = ($urandom() % 4) == 0;
      if (r == 0) stall();
      else if (r == 1) dsel();
      else if (r < 5) adv(1'($urandom()), 4'($urandom()));
      else if (r < 10) wr(int'($urandom()), 4'($urandom()));
      else rd(int'($urandom()));
    end
    oe_n = 1'b0;
    dsel(); dsel(); dsel();
    report();
  end
endmodule